// File: doc/BRIEF.md
# Translation Buffer with Accessed/Dirty Flag Assist

This block is a small, fully associative translation buffer. Each entry maps a virtual page number to a physical page number and also keeps a private copy of two page-table flags: accessed and dirty. A request carries a virtual address and a load/store indication. When the lookup hits and the flags the access needs are already set in the entry, the physical address comes back on the next cycle and nothing else happens. When the lookup hits but a needed flag is clear, the block raises an assist write toward memory so that the page-table entry gets the flag. It waits for that write to be acknowledged, then sets the flag in its own copy and only then returns the translation.

The buffer is deliberately not kept coherent with the page tables. The hit path never reads the in-memory entry. If a cached flag is already set, no write is issued, even if memory has since cleared that flag. Software that edits page-table entries must flush the buffer, either completely or for one virtual page. Entries are installed by an external refill port into slots chosen in rotating order. Walking the page tables is done elsewhere.

Top module: `pte_flag_tlb`

## Requirements
- R1: After reset, no entry is valid, `reqReady` is 1, and `rspValid` and `assistValid` are 0.
- R2: A request accepted in a cycle where `reqValid` and `reqReady` are both 1, and which hits an entry whose needed flags are set, produces `rspValid`=1 and `rspHit`=1 in the next cycle. `rspPaddr` is then the entry's physical page number concatenated with the low 12 address bits (4 KiB pages, virtual page number = `reqVaddr[31:12]`).
- R3: A request whose page is not in any valid entry responds in the next cycle with `rspHit`=0 and `rspPaddr`=0, and never raises an assist.
- R4: A load hit on an entry with a clear accessed flag raises `assistValid` in the next cycle with `assistSetAcc`=1, `assistSetDirty`=0 and `assistVpn` equal to the request's page. The response (hit, translated address) follows in the cycle after `assistAck` is sampled high. Afterwards the entry's accessed flag is set, so a later load to that page needs no assist.
- R5: A store hit on an entry with a clear dirty flag raises an assist with `assistSetDirty`=1. `assistSetAcc` is 1 exactly when the accessed flag is also clear, so both flags are written in one assist. Both flags are set in the entry afterwards.
- R6: When the flags the access needs are already set in the entry, no assist is raised, whatever the page table in memory holds (a load needs only accessed; a store needs accessed and dirty).
- R7: `flushAll` sampled high invalidates every entry; a request in the following cycle misses.
- R8: `flushVpnValid` sampled high invalidates only the entry holding `flushVpn`; other entries keep hitting in the following cycle.
- R9: Refills fill slots in rotating order, starting at slot 0 after reset and wrapping after 8 slots, whether or not the slot is valid; the ninth refill after a full flush therefore evicts the page that went into the slot the pointer had reached.
- R10: A refill sampled in the same cycle as `flushAll` or `flushVpnValid` is dropped and does not advance the rotating pointer.
- R11: While an assist is outstanding, `reqReady` is 0, and `assistValid`, `assistVpn`, `assistSetAcc` and `assistSetDirty` stay unchanged until `assistAck` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqStore | input | 1 | 1 = store access, 0 = load access |
| reqVaddr | input | 32 | Virtual address of the request |
| reqReady | output | 1 | Block can accept a request this cycle |
| rspValid | output | 1 | Response present (one cycle) |
| rspHit | output | 1 | Response hit a valid entry |
| rspPaddr | output | 32 | Translated physical address (0 on a miss) |
| refillValid | input | 1 | Install an entry this cycle |
| refillVpn | input | 20 | Virtual page number to install |
| refillPpn | input | 20 | Physical page number to install |
| refillAcc | input | 1 | Accessed flag copy to install |
| refillDirty | input | 1 | Dirty flag copy to install |
| flushAll | input | 1 | Invalidate all entries |
| flushVpnValid | input | 1 | Invalidate the entry holding `flushVpn` |
| flushVpn | input | 20 | Virtual page number to invalidate |
| assistValid | output | 1 | Flag-update write toward memory is pending |
| assistVpn | output | 20 | Page whose table entry is to be updated |
| assistSetAcc | output | 1 | Write must set the accessed flag |
| assistSetDirty | output | 1 | Write must set the dirty flag |
| assistAck | input | 1 | Memory has completed the flag update |

## Verification
A response that needs no assist is registered on the accepting edge, so the bench samples it one nanosecond after that edge. An assist request appears after the same edge, and the bench checks it there. The bench then holds off `assistAck` for zero to three cycles and samples the final response one nanosecond after the edge that takes the acknowledge. Flushes and refills change state on the edge that samples them, so every lookup that checks their effect is issued in a later cycle. Expected values come from a bench model of slots, flags and rotating pointer. That model is updated only when the corresponding stimulus completes.

// File: rtl/tlbad_pkg.sv
package tlbad_pkg;

  // Strobes issued by the control FSM to the datapath each cycle.
  typedef struct packed {
    logic respondNow;   // accepted request answered directly
    logic enterAssist;  // accepted request needs a flag write
    logic assistDone;   // outstanding flag write acknowledged
  } tlbStrobes_t;

endpackage

// File: rtl/tlbad_datapath.sv
module tlbad_datapath
  import tlbad_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tlbStrobes_t               strobes,
  input  logic                      reqStore,
  input  logic [VA_W-1:0]           reqVaddr,
  input  logic                      refillValid,
  input  logic [VA_W-PAGE_BITS-1:0] refillVpn,
  input  logic [PA_W-PAGE_BITS-1:0] refillPpn,
  input  logic                      refillAcc,
  input  logic                      refillDirty,
  input  logic                      flushAll,
  input  logic                      flushVpnValid,
  input  logic [VA_W-PAGE_BITS-1:0] flushVpn,
  output logic                      needAssist,
  output logic                      rspValid,
  output logic                      rspHit,
  output logic [PA_W-1:0]           rspPaddr,
  output logic [VA_W-PAGE_BITS-1:0] assistVpn,
  output logic                      assistSetAcc,
  output logic                      assistSetDirty
);

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] entAcc;
  logic [ENTRIES-1:0] entDirty;
  logic [VPN_W-1:0]   entVpn [ENTRIES];
  logic [PPN_W-1:0]   entPpn [ENTRIES];
  logic [IDX_W-1:0]   rrPtr;

  logic [VPN_W-1:0]     reqVpn;
  logic [PAGE_BITS-1:0] reqOff;
  logic [ENTRIES-1:0]   matchVec;
  logic [ENTRIES-1:0]   flushVec;
  logic [IDX_W-1:0]     hitIdx;
  logic                 lookupHit;
  logic [PPN_W-1:0]     hitPpn;
  logic                 hitAcc;
  logic                 hitDirty;
  logic                 refillFire;
  logic                 setOk;

  // Request held while its flag write is outstanding.
  logic [VPN_W-1:0]     holdVpn;
  logic [PPN_W-1:0]     holdPpn;
  logic [PAGE_BITS-1:0] holdOff;
  logic [IDX_W-1:0]     holdIdx;
  logic                 holdSetA;
  logic                 holdSetD;

  assign reqVpn = reqVaddr[VA_W-1:PAGE_BITS];
  assign reqOff = reqVaddr[PAGE_BITS-1:0];

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cam
      assign matchVec[g] = entValid[g] && (entVpn[g] == reqVpn);
      assign flushVec[g] = flushAll || (flushVpnValid && entValid[g] && (entVpn[g] == flushVpn));
    end
  endgenerate

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign lookupHit  = |matchVec;
  assign hitPpn     = entPpn[hitIdx];
  assign hitAcc     = entAcc[hitIdx];
  assign hitDirty   = entDirty[hitIdx];
  assign needAssist = lookupHit && (!hitAcc || (reqStore && !hitDirty));
  assign refillFire = refillValid && !flushAll && !flushVpnValid;
  assign setOk      = entValid[holdIdx] && (entVpn[holdIdx] == holdVpn);

  // Entry storage: flag set on assist, then flush, then refill (last wins).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      entAcc   <= '0;
      entDirty <= '0;
      rrPtr    <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entVpn[i] <= '0;
        entPpn[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobes.assistDone && setOk && (holdIdx == IDX_W'(i))) begin
          entAcc[i]   <= entAcc[i]   | holdSetA;
          entDirty[i] <= entDirty[i] | holdSetD;
        end
        if (flushVec[i]) entValid[i] <= 1'b0;
        if (refillFire && (rrPtr == IDX_W'(i))) begin
          entValid[i] <= 1'b1;
          entVpn[i]   <= refillVpn;
          entPpn[i]   <= refillPpn;
          entAcc[i]   <= refillAcc;
          entDirty[i] <= refillDirty;
        end
      end
      if (refillFire) rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  // Hold registers for an assist.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdVpn  <= '0;
      holdPpn  <= '0;
      holdOff  <= '0;
      holdIdx  <= '0;
      holdSetA <= 1'b0;
      holdSetD <= 1'b0;
    end else if (strobes.enterAssist) begin
      holdVpn  <= reqVpn;
      holdPpn  <= hitPpn;
      holdOff  <= reqOff;
      holdIdx  <= hitIdx;
      holdSetA <= !hitAcc;
      holdSetD <= reqStore && !hitDirty;
    end
  end

  // Response register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspPaddr <= '0;
    end else begin
      rspValid <= strobes.respondNow || strobes.assistDone;
      if (strobes.respondNow) begin
        rspHit   <= lookupHit;
        rspPaddr <= lookupHit ? {hitPpn, reqOff} : '0;
      end else if (strobes.assistDone) begin
        rspHit   <= 1'b1;
        rspPaddr <= {holdPpn, holdOff};
      end
    end
  end

  assign assistVpn      = holdVpn;
  assign assistSetAcc   = holdSetA;
  assign assistSetDirty = holdSetD;

  p_flush_all_r7: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> (entValid == '0));

  p_rr_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    refillFire |=> (rrPtr == (($past(rrPtr) == LAST_IDX) ? '0 : $past(rrPtr) + 1'b1)));

  p_rr_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && (flushAll || flushVpnValid)) |=> $stable(rrPtr));

  p_acc_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.assistDone && setOk && holdSetA && !(refillFire && rrPtr == holdIdx))
      |=> entAcc[$past(holdIdx)]);

  p_dirty_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.assistDone && setOk && holdSetD && !(refillFire && rrPtr == holdIdx))
      |=> entDirty[$past(holdIdx)]);

endmodule

// File: rtl/tlbad_control.sv
module tlbad_control
  import tlbad_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        needAssist,
  input  logic        assistAck,
  output tlbStrobes_t strobes,
  output logic        reqReady,
  output logic        assistValid
);

  typedef enum logic {ST_IDLE, ST_ASSIST} ctlState_e;
  ctlState_e stateQ, stateD;

  logic accept;

  assign reqReady    = (stateQ == ST_IDLE);
  assign assistValid = (stateQ == ST_ASSIST);
  assign accept      = reqValid && reqReady;

  always_comb begin
    strobes.respondNow  = accept && !needAssist;
    strobes.enterAssist = accept && needAssist;
    strobes.assistDone  = assistValid && assistAck;
    stateD = stateQ;
    if (strobes.enterAssist)     stateD = ST_ASSIST;
    else if (strobes.assistDone) stateD = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  p_assist_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ASSIST && !assistAck) |=> (stateQ == ST_ASSIST));

endmodule

// File: rtl/pte_flag_tlb.sv
module pte_flag_tlb
  import tlbad_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqStore,
  input  logic [VA_W-1:0]           reqVaddr,
  output logic                      reqReady,
  output logic                      rspValid,
  output logic                      rspHit,
  output logic [PA_W-1:0]           rspPaddr,
  input  logic                      refillValid,
  input  logic [VA_W-PAGE_BITS-1:0] refillVpn,
  input  logic [PA_W-PAGE_BITS-1:0] refillPpn,
  input  logic                      refillAcc,
  input  logic                      refillDirty,
  input  logic                      flushAll,
  input  logic                      flushVpnValid,
  input  logic [VA_W-PAGE_BITS-1:0] flushVpn,
  output logic                      assistValid,
  output logic [VA_W-PAGE_BITS-1:0] assistVpn,
  output logic                      assistSetAcc,
  output logic                      assistSetDirty,
  input  logic                      assistAck
);

  tlbStrobes_t strobes;
  logic        needAssist;

  tlbad_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .needAssist (needAssist),
    .assistAck  (assistAck),
    .strobes    (strobes),
    .reqReady   (reqReady),
    .assistValid(assistValid)
  );

  tlbad_datapath #(
    .ENTRIES  (ENTRIES),
    .VA_W     (VA_W),
    .PA_W     (PA_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .reqStore      (reqStore),
    .reqVaddr      (reqVaddr),
    .refillValid   (refillValid),
    .refillVpn     (refillVpn),
    .refillPpn     (refillPpn),
    .refillAcc     (refillAcc),
    .refillDirty   (refillDirty),
    .flushAll      (flushAll),
    .flushVpnValid (flushVpnValid),
    .flushVpn      (flushVpn),
    .needAssist    (needAssist),
    .rspValid      (rspValid),
    .rspHit        (rspHit),
    .rspPaddr      (rspPaddr),
    .assistVpn     (assistVpn),
    .assistSetAcc  (assistSetAcc),
    .assistSetDirty(assistSetDirty)
  );

  p_rsp_after_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    (assistValid && assistAck) |=> (rspValid && rspHit));

  p_assist_has_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    assistValid |-> (assistSetAcc || assistSetDirty));

  p_assist_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (assistValid && !assistAck) |=> (assistValid && $stable(assistVpn)
      && $stable(assistSetAcc) && $stable(assistSetDirty)));

  p_no_rsp_while_wait_r11: assert property (@(posedge clk) disable iff (!rstN)
    (assistValid && !assistAck) |=> !rspValid);

endmodule

// File: tb/pte_flag_tlb_tb_top.sv
module pte_flag_tlb_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqStore = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqReady, rspValid, rspHit;
  logic [31:0] rspPaddr;
  logic        refillValid = 1'b0, refillAcc = 1'b0, refillDirty = 1'b0;
  logic [19:0] refillVpn = '0, refillPpn = '0;
  logic        flushAll = 1'b0, flushVpnValid = 1'b0;
  logic [19:0] flushVpn = '0;
  logic        assistValid, assistSetAcc, assistSetDirty;
  logic [19:0] assistVpn;
  logic        assistAck = 1'b0;

  always #5 clk = ~clk;

  pte_flag_tlb dut_i (.*);

  int checks = 0, errs = 0;
  bit doneFlag = 1'b0;

  // Bench model of the buffer.
  bit          mV [8];
  logic [19:0] mVpn [8];
  logic [19:0] mPpn [8];
  bit          mA [8];
  bit          mD [8];
  int          mPtr = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int findIdx(input logic [19:0] vpn);
    int r = -1;
    for (int i = 0; i < 8; i++) if (mV[i] && mVpn[i] == vpn) r = i;
    return r;
  endfunction

  function automatic logic [31:0] expAddr(input int idx, input logic [11:0] off);
    return (idx < 0) ? 32'h0 : {mPpn[idx], off};
  endfunction

  task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn, input bit a, input bit d);
    @(negedge clk);
    refillValid = 1'b1; refillVpn = vpn; refillPpn = ppn; refillAcc = a; refillDirty = d;
    @(posedge clk); #1;
    refillValid = 1'b0;
    mV[mPtr] = 1'b1; mVpn[mPtr] = vpn; mPpn[mPtr] = ppn; mA[mPtr] = a; mD[mPtr] = d;
    mPtr = (mPtr + 1) % 8;
  endtask

  task automatic flushEverything();
    @(negedge clk);
    flushAll = 1'b1;
    @(posedge clk); #1;
    flushAll = 1'b0;
    for (int i = 0; i < 8; i++) mV[i] = 1'b0;
  endtask

  task automatic flushPage(input logic [19:0] vpn);
    int idx;
    @(negedge clk);
    flushVpnValid = 1'b1; flushVpn = vpn;
    @(posedge clk); #1;
    flushVpnValid = 1'b0;
    idx = findIdx(vpn);
    if (idx >= 0) mV[idx] = 1'b0;
  endtask

  // One request, checked against the model; ackDelay idle cycles before ack.
  task automatic request(input bit store, input logic [31:0] va, input int ackDelay, input string tag);
    int idx;
    bit expHit, needA, expSetA, expSetD;
    idx     = findIdx(va[31:12]);
    expHit  = (idx >= 0);
    needA   = expHit && (!mA[idx] || (store && !mD[idx]));
    expSetA = expHit && !mA[idx];
    expSetD = expHit && store && !mD[idx];
    @(negedge clk);
    check(reqReady == 1'b1, "R11 ready before request", 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqStore = store; reqVaddr = va;
    @(posedge clk); #1;
    reqValid = 1'b0;
    if (!needA) begin
      check(assistValid == 1'b0, {tag, " no assist"}, 64'(assistValid), 64'd0);
      check(rspValid == 1'b1 && rspHit == expHit && rspPaddr == expAddr(idx, va[11:0]),
            {tag, " direct response"}, {31'd0, rspValid, rspHit, rspPaddr},
            {31'd0, 1'b1, expHit, expAddr(idx, va[11:0])});
    end else begin
      check(assistValid && !rspValid && !reqReady && assistVpn == va[31:12]
            && assistSetAcc == expSetA && assistSetDirty == expSetD,
            {tag, " assist raised"}, {assistValid, rspValid, reqReady, assistSetAcc, assistSetDirty, assistVpn},
            {1'b1, 1'b0, 1'b0, expSetA, expSetD, va[31:12]});
      for (int k = 0; k < ackDelay; k++) begin
        @(posedge clk); #1;
        check(assistValid && !rspValid && !reqReady && assistVpn == va[31:12]
              && assistSetAcc == expSetA && assistSetDirty == expSetD,
              "R11 assist held", {assistValid, rspValid, reqReady, assistSetAcc, assistSetDirty, assistVpn},
              {1'b1, 1'b0, 1'b0, expSetA, expSetD, va[31:12]});
      end
      assistAck = 1'b1;
      @(posedge clk); #1;
      assistAck = 1'b0;
      check(rspValid && rspHit && !assistValid && rspPaddr == expAddr(idx, va[11:0]),
            {tag, " response after ack"}, {rspValid, rspHit, assistValid, rspPaddr},
            {1'b1, 1'b1, 1'b0, expAddr(idx, va[11:0])});
      mA[idx] = 1'b1;
      if (store) mD[idx] = 1'b1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin mV[i] = 0; mA[i] = 0; mD[i] = 0; mVpn[i] = '0; mPpn[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    check(!rspValid && !assistValid && reqReady, "R1 reset outputs",
          {rspValid, assistValid, reqReady}, 3'b001);
    request(1'b0, 32'h0001_0123, 0, "R1 empty buffer");
    request(1'b1, 32'h0005_0fff, 0, "R3 miss");

    // Accessed/dirty assists.
    refill(20'h00010, 20'hABCDE, 1'b0, 1'b0);
    request(1'b0, 32'h0001_0456, 2, "R4 load clear accessed");
    request(1'b0, 32'h0001_0004, 0, "R4 load after set");
    request(1'b1, 32'h0001_0ff8, 1, "R5 store clear dirty");
    request(1'b1, 32'h0001_0000, 0, "R6 store after set");
    refill(20'h00020, 20'h12345, 1'b0, 1'b0);
    request(1'b1, 32'h0002_0010, 3, "R5 store both clear");
    refill(20'h00030, 20'h00777, 1'b1, 1'b1);
    request(1'b1, 32'h0003_0abc, 0, "R6 store flags set memory clear");
    refill(20'h00040, 20'h00888, 1'b1, 1'b0);
    request(1'b0, 32'h0004_0001, 0, "R6 load with dirty clear");
    request(1'b0, 32'h0002_0020, 0, "R2 hit translation");

    // Flushes.
    flushPage(20'h00010);
    request(1'b0, 32'h0001_0456, 0, "R8 flushed page misses");
    request(1'b0, 32'h0002_0456, 0, "R8 other page hits");
    flushEverything();
    request(1'b0, 32'h0002_0456, 0, "R7 after flush all");
    request(1'b0, 32'h0004_0456, 0, "R7 after flush all");

    // Rotating replacement: nine refills after a flush.
    for (int k = 0; k < 9; k++) refill(20'h00100 + 20'(k), 20'h00200 + 20'(k), 1'b1, 1'b1);
    for (int k = 0; k < 9; k++) request(1'b0, {20'h00100 + 20'(k), 12'h3c0}, 0, "R9 rotating slots");

    // Refill coinciding with a flush is dropped.
    @(negedge clk);
    refillValid = 1'b1; refillVpn = 20'h00333; refillPpn = 20'h00444; refillAcc = 1; refillDirty = 1;
    flushAll = 1'b1;
    @(posedge clk); #1;
    refillValid = 1'b0; flushAll = 1'b0;
    for (int i = 0; i < 8; i++) mV[i] = 1'b0;
    request(1'b0, 32'h0033_3000, 0, "R10 refill with flush all");
    @(negedge clk);
    refillValid = 1'b1; refillVpn = 20'h00555; refillPpn = 20'h00666;
    flushVpnValid = 1'b1; flushVpn = 20'h00999;
    @(posedge clk); #1;
    refillValid = 1'b0; flushVpnValid = 1'b0;
    request(1'b0, 32'h0055_5000, 0, "R10 refill with page flush");
    refill(20'h00777, 20'h00abc, 1'b1, 1'b1);
    request(1'b0, 32'h0077_7010, 0, "R10 pointer not advanced");

    // Constrained random mix.
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [19:0] vpn;
      vpn = 20'h00800 + 20'($urandom_range(0, 11));
      op = $urandom_range(0, 19);
      if (op < 12 || (op < 16 && findIdx(vpn) >= 0)) begin
        request(1'($urandom_range(0, 1)), {vpn, 12'($urandom)}, $urandom_range(0, 3), "R2 R4 R5 R6 random");
      end else if (op < 16) begin
        refill(vpn, 20'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end else if (op < 19) begin
        flushPage(vpn);
      end else begin
        flushEverything();
      end
    end

    doneFlag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

endmodule